// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog and interval timer for a system controller. An 8-bit up-counter advances once per prescaler tick. The tick period is a power of two between 32 and 4096 clock cycles, picked by a 3-bit select field. When the counter wraps from all ones to zero, the block latches a sticky overflow flag. In interval mode the flag drives a level interrupt. In watchdog mode the wrap instead produces a single-cycle reset request, which a separate reset generator widens.

Software reaches two 8-bit registers, the counter and the control/status register, over a plain register port. Writes are 16-bit words. The upper byte of each write must carry the key that belongs to the target register, or the write is dropped. Reads return one byte from a combinational mux. Read offsets are decoded separately from write offsets, so a write aimed at a read offset has no effect. The register port is a simple strobe interface with no back-pressure: a write is taken on any clock edge where `wr_en` is high, and `rd_data` follows `rd_addr` in the same cycle.

Top module: `keyed_wdt`

## Requirements
- R1: After reset both registers read 0x00, so the timer is disabled in interval mode with select code 0, and `ovf_irq` and `wdt_rst_req` are low.
- R2: A write at the counter write offset (0x0) whose upper byte is 0x5A loads its lower byte into the counter, and the counter reads back at the counter read offset (0x1).
- R3: A write at the control write offset (0x2) whose upper byte is 0xA5 loads the enable (bit 7), mode (bit 6, 1 = reset request) and select (bits 2:0) fields. The control register read offset is 0x3, where bits 5:4 read 0 and bit 3 reads the overflow flag.
- R4: A write whose upper byte is not the key of the addressed register leaves that register unchanged, including when the key of the other register is used.
- R5: Writes at a read offset change nothing, and a read from an offset that maps to no register returns 0x00.
- R6: Select code k gives a tick period of 2^(5+k) cycles. After the enabling write, the counter first advances 2^(5+k) cycles later, so a counter started at S wraps 2^(5+k)·(256−S) cycles after that write.
- R7: While disabled, the counter holds its value and the prescaler is held at zero, so re-enabling restarts a full tick period.
- R8: A wrap sets the overflow flag (bit 3). In interval mode, `ovf_irq` is high whenever the flag is set.
- R9: In watchdog mode a wrap raises `wdt_rst_req` for exactly one cycle, and `ovf_irq` stays low.
- R10: A keyed control write with bit 3 = 0 clears the flag, and writing 1 leaves it as it was. A wrap in the same cycle as a clearing write leaves the flag set.
- R11: A keyed counter write while running takes priority over a tick and postpones the wrap. The prescaler phase is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, taken at the clock edge |
| wr_addr | input | 4 | Write offset |
| wr_data | input | 16 | Write word: key in upper byte, value in lower byte |
| rd_addr | input | 4 | Read offset |
| rd_data | output | 8 | Read byte, combinational from `rd_addr` |
| ovf_irq | output | 1 | Interval-mode overflow interrupt (level) |
| wdt_rst_req | output | 1 | Watchdog-mode reset request (one-cycle pulse) |

## Verification
The hardest situation to reach from the ports is a clearing control write that lands on the very edge where the counter wraps. To hit it, the bench counts edges from the enabling write and issues the clear so that it is captured on the computed wrap edge. A counter reload in the middle of a tick period is staged the same way: the reload is placed a fixed number of cycles after enabling, and the postponed wrap edge is predicted from the undisturbed prescaler phase. Every select code is run to overflow from a near-full counter, and the interrupt is checked one cycle before the predicted wrap edge and again on it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam logic [BYTE_W-1:0] KEY_CNT = 8'h5A;
  localparam logic [BYTE_W-1:0] KEY_CSR = 8'hA5;
  localparam int BIT_EN   = 7;
  localparam int BIT_MODE = 6;
  localparam int BIT_FLAG = 3;

  typedef struct packed {
    logic             en;
    logic             mode;
    logic             flag;
    logic [SEL_W-1:0] sel;
  } csr_t;
endpackage

// File: rtl/wdt_busdec.sv
module wdt_busdec
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CNT_WR = 'h0,
  parameter logic [ADDR_W-1:0] CNT_RD = 'h1,
  parameter logic [ADDR_W-1:0] CSR_WR = 'h2,
  parameter logic [ADDR_W-1:0] CSR_RD = 'h3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [2*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [BYTE_W-1:0]   cnt_val,
  input  csr_t                csr_val,
  output logic                cnt_load,
  output logic                csr_load,
  output logic [BYTE_W-1:0]   wr_byte,
  output logic [BYTE_W-1:0]   rd_data
);
  logic [BYTE_W-1:0] key_hi;
  logic [BYTE_W-1:0] csr_byte;

  assign key_hi  = wr_data[2*BYTE_W-1:BYTE_W];
  assign wr_byte = wr_data[BYTE_W-1:0];

  assign cnt_load = wr_en && (wr_addr == CNT_WR) && (key_hi == KEY_CNT);
  assign csr_load = wr_en && (wr_addr == CSR_WR) && (key_hi == KEY_CSR);

  always_comb begin
    csr_byte           = '0;
    csr_byte[BIT_EN]   = csr_val.en;
    csr_byte[BIT_MODE] = csr_val.mode;
    csr_byte[BIT_FLAG] = csr_val.flag;
    csr_byte[SEL_W-1:0] = csr_val.sel;
  end

  always_comb begin
    if (rd_addr == CNT_RD)      rd_data = cnt_val;
    else if (rd_addr == CSR_RD) rd_data = csr_byte;
    else                        rd_data = '0;
  end

  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != CNT_RD && rd_addr != CSR_RD) |-> rd_data == '0); // R5
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int BASE_LOG = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PRE_W = BASE_LOG + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < BASE_LOG + int'(sel_i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_q <= '0;
    else if (en_i)  pre_q <= pre_q + 1'b1;
    else            pre_q <= '0;
  end

  assign tick_o = en_i && ((pre_q & mask) == mask);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R6
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_val_i,
  output logic [BYTE_W-1:0] cnt_o,
  output logic              wrap_o
);
  logic [BYTE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && !load_i && (&cnt_q);

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && (&cnt_q)) |=> cnt_q == '0); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BASE_LOG = 5,
  parameter logic [ADDR_W-1:0] CNT_WR = 'h0,
  parameter logic [ADDR_W-1:0] CNT_RD = 'h1,
  parameter logic [ADDR_W-1:0] CSR_WR = 'h2,
  parameter logic [ADDR_W-1:0] CSR_RD = 'h3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          ovf_irq,
  output logic          wdt_rst_req
);
  csr_t              csr_q;
  logic              cnt_load, csr_load, tick, wrap;
  logic [BYTE_W-1:0] wr_byte, cnt_val;
  logic              clr_req;

  wdt_busdec #(
    .ADDR_W(ADDR_W), .CNT_WR(CNT_WR), .CNT_RD(CNT_RD),
    .CSR_WR(CSR_WR), .CSR_RD(CSR_RD)
  ) i_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .cnt_val(cnt_val),
    .csr_val(csr_q), .cnt_load(cnt_load), .csr_load(csr_load),
    .wr_byte(wr_byte), .rd_data(rd_data)
  );

  wdt_prescaler #(.BASE_LOG(BASE_LOG)) i_pre (
    .clk(clk), .rst_n(rst_n), .en_i(csr_q.en), .sel_i(csr_q.sel),
    .tick_o(tick)
  );

  wdt_counter i_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(cnt_load),
    .load_val_i(wr_byte), .cnt_o(cnt_val), .wrap_o(wrap)
  );

  assign clr_req = csr_load && !wr_byte[BIT_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q       <= '0;
      wdt_rst_req <= 1'b0;
    end else begin
      if (csr_load) begin
        csr_q.en   <= wr_byte[BIT_EN];
        csr_q.mode <= wr_byte[BIT_MODE];
        csr_q.sel  <= wr_byte[SEL_W-1:0];
      end
      if (wrap)         csr_q.flag <= 1'b1;
      else if (clr_req) csr_q.flag <= 1'b0;
      wdt_rst_req <= wrap && csr_q.mode;
    end
  end

  assign ovf_irq = csr_q.flag && !csr_q.mode;

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q.flag && !clr_req) |=> csr_q.flag); // R10
  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_load |=> $stable(csr_q.sel) && $stable(csr_q.en)); // R4
  AST_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> !csr_q.mode); // R9
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        ovf_irq, wdt_rst_req;

  localparam logic [3:0] A_CNT_WR = 4'h0, A_CNT_RD = 4'h1;
  localparam logic [3:0] A_CSR_WR = 4'h2, A_CSR_RD = 4'h3;

  keyed_wdt i_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ovf_irq(ovf_irq), .wdt_rst_req(wdt_rst_req)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // kind 0: ovf_irq, 1: wdt_rst_req, 2: rd_data
  typedef struct { int at; int kind; logic [7:0] exp; string req; } item_t;
  item_t sb[$];

  task automatic push(input int at, input int kind, input logic [7:0] exp, input string req);
    item_t it;
    it.at = at; it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      logic [7:0] act;
      item_t it;
      it = sb.pop_front();
      case (it.kind)
        0: act = {7'd0, ovf_irq};
        1: act = {7'd0, wdt_rst_req};
        default: act = rd_data;
      endcase
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%02h expected=%02h",
                 it.req, it.kind, cyc, act, it.exp);
      end
    end
  end

  // all tasks are called at a negedge and return at a negedge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    rd_addr = a;
    push(cyc + 1, 2, exp, req);
    @(negedge clk);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    int w, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    push(cyc + 1, 0, 8'h00, "R1");
    push(cyc + 1, 1, 8'h00, "R1");
    rd_chk(A_CSR_RD, 8'h00, "R1");
    rd_chk(A_CNT_RD, 8'h00, "R1");

    // R2 keyed counter load
    wr(A_CNT_WR, 16'h5A3C);
    rd_chk(A_CNT_RD, 8'h3C, "R2");

    // R4 wrong keys
    wr(A_CNT_WR, 16'h5B11);
    rd_chk(A_CNT_RD, 8'h3C, "R4");
    wr(A_CNT_WR, 16'hA511);
    rd_chk(A_CNT_RD, 8'h3C, "R4");
    wr(A_CSR_WR, 16'h5A87);
    rd_chk(A_CSR_RD, 8'h00, "R4");

    // R3 field layout: flag cannot be set, bits 5:4 read zero
    wr(A_CSR_WR, 16'hA57F);
    rd_chk(A_CSR_RD, 8'h47, "R3");
    wr(A_CSR_WR, 16'hA500);
    rd_chk(A_CSR_RD, 8'h00, "R3");

    // R5 read offsets are not writable, unmapped read is zero
    wr(A_CNT_RD, 16'h5A99);
    rd_chk(A_CNT_RD, 8'h3C, "R5");
    wr(A_CSR_RD, 16'hA580);
    rd_chk(A_CSR_RD, 8'h00, "R5");
    rd_chk(4'hF, 8'h00, "R5");

    // R6 / R8 every select code
    for (int k = 0; k < 8; k++) begin
      wr(A_CNT_WR, 16'h5AFC);
      wr(A_CSR_WR, 16'hA580 | 16'(k));
      w = cyc;
      n = (32 << k) * 4;
      push(w + n - 1, 0, 8'h00, "R6");
      push(w + n, 0, 8'h01, "R6");
      wait_to(w + n + 1);
      rd_chk(A_CSR_RD, 8'h88 | 8'(k), "R8");
      wr(A_CSR_WR, 16'hA500 | 16'(k));
      push(cyc + 1, 0, 8'h00, "R10");
      rd_chk(A_CSR_RD, 8'(k), "R10");
    end

    // R10 writing 1 keeps flag; clear colliding with wrap
    wr(A_CNT_WR, 16'h5AFE);
    wr(A_CSR_WR, 16'hA580);
    w = cyc;
    wait_to(w + 65);
    wr(A_CSR_WR, 16'hA588);
    rd_chk(A_CSR_RD, 8'h88, "R10");
    wr(A_CSR_WR, 16'hA580);
    rd_chk(A_CSR_RD, 8'h80, "R10");
    wr(A_CSR_WR, 16'hA500);
    wr(A_CNT_WR, 16'h5AFF);
    wr(A_CSR_WR, 16'hA580);
    w = cyc;
    wait_to(w + 31);
    wr(A_CSR_WR, 16'hA580);
    rd_chk(A_CSR_RD, 8'h88, "R10");
    wr(A_CSR_WR, 16'hA500);

    // R9 watchdog mode pulse
    wr(A_CNT_WR, 16'h5AFF);
    wr(A_CSR_WR, 16'hA5C0);
    w = cyc;
    push(w + 31, 1, 8'h00, "R9");
    push(w + 32, 1, 8'h01, "R9");
    push(w + 32, 0, 8'h00, "R9");
    push(w + 33, 1, 8'h00, "R9");
    wait_to(w + 34);
    rd_chk(A_CSR_RD, 8'hC8, "R9");
    wr(A_CSR_WR, 16'hA500);

    // R7 disable holds counter and clears prescaler
    wr(A_CNT_WR, 16'h5AF0);
    wr(A_CSR_WR, 16'hA580);
    w = cyc;
    wait_to(w + 20);
    wr(A_CSR_WR, 16'hA500);
    rd_chk(A_CNT_RD, 8'hF0, "R7");
    repeat (50) @(negedge clk);
    rd_chk(A_CNT_RD, 8'hF0, "R7");
    wr(A_CSR_WR, 16'hA580);
    w = cyc;
    push(w + 511, 0, 8'h00, "R7");
    push(w + 512, 0, 8'h01, "R7");
    wait_to(w + 513);
    wr(A_CSR_WR, 16'hA500);

    // R11 reload while running postpones wrap
    wr(A_CNT_WR, 16'h5AF0);
    wr(A_CSR_WR, 16'hA580);
    w = cyc;
    wait_to(w + 299);
    wr(A_CNT_WR, 16'h5AF0);
    push(w + 512, 0, 8'h00, "R11");
    push(w + 799, 0, 8'h00, "R11");
    push(w + 800, 0, 8'h01, "R11");
    wait_to(w + 802);
    wr(A_CSR_WR, 16'hA500);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule